// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master peripheral that software drives through a small bank of 32-bit registers on a simple memory-mapped bus. Software first sets the clock polarity, the clock phase, the word size and the bit orders. It then chooses one of eight active-low chip-select lines and asserts it. Each write to the transmit-word register shifts one 8-bit or 16-bit word out on MOSI while the same number of bits is shifted in from MISO.

The block does not divide the clock itself. An attached divider supplies a one-cycle `sck_tick` pulse, and every accepted pulse during a word moves SCK by one edge. The MISO capture point can be moved later by zero to three system clock cycles after the sampling edge. This helps at high SCK rates. When the last bit has been captured, the received word goes into the receive register and a completion flag is set. Software clears the flag by writing to the cause register.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, the registers read as follows. Control (0x00) reads 0 and configuration (0x04) reads 0. Timing (0x18) reads 0x40, which is a delay field of 1. Cause (0x10), receive word (0x0C) and transmit word (0x08) read 0. All `spi_cs_n` lines are high, SCK is low and MOSI is low.
- R2: Control bits [4:2] hold a chip-select index and bit 0 asserts it. `spi_cs_n[index]` is low only while bit 0 is 1. Every other line stays high.
- R3: A write to 0x08 while idle starts one word. Control bit 1 (busy) reads 1 from the next cycle until completion. MOSI is 0 whenever the block is idle.
- R4: While idle, SCK equals configuration bit 11 (CPOL). During a word, each `sck_tick` pulse toggles SCK, for 2·W edges in all, where W is the word width. Pulses outside a word are ignored.
- R5: Configuration bit 12 (CPHA) selects the capture edges. With CPHA 0, the first bit is on MOSI when the word starts, MISO is taken on the odd-numbered edges (1st, 3rd, …) and MOSI advances on the even-numbered edges. With CPHA 1, MOSI advances on the odd-numbered edges after the first, and MISO is taken on the even-numbered edges.
- R6: Configuration bit 5 set gives 16-bit words, using bits [15:0] of the write. Bit 5 clear gives 8-bit words, using bits [7:0].
- R7: Configuration bit 13 clear sends the most significant bit first. Bit 13 set sends the least significant bit first.
- R8: Configuration bit 14 sets the receive order independently of bit 13. When bit 14 is clear, the first captured bit becomes the most significant bit. When bit 14 is set, the first captured bit becomes bit 0.
- R9: Timing bits [7:6] hold a delay N. MISO is captured N system clock cycles after the clock cycle of the sampling edge.
- R10: One cycle after both the final edge and the final capture, several things happen in the same cycle. The receive word is written to 0x0C, zero-extended. Cause bit 0 is set and busy clears.
- R11: Any write to 0x10 clears the cause bit. If the write falls in the completion cycle, the completion wins and the bit is set.
- R12: A write to 0x08 while busy is ignored. The stored transmit word, which reads back at 0x08, is unchanged, and the running word continues.
- R13: A transmit word of zero shifts out zeros, and the word received during it is still captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| sck_tick | input | 1 | Edge pulse from the external divider |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 8 | Active-low chip selects |

## Verification
Timing of results:

- **Register writes and ticks:** a register write takes effect on the clock edge that accepts it, and the chip selects, busy flag and read data show it straight after that edge. A tick accepted at an edge moves SCK and, where due, MOSI right after that same edge.
- **MISO capture:** the capture happens N cycles after the sampling edge.
- **Completion:** the receive word, the cause bit and busy all change one cycle after the later of the last edge and the last capture.

How the bench follows this: it drives every input at the falling edge and advances its behavioural model by one rising edge with those inputs. At the following falling edge it compares SCK, MOSI, the chip selects and any read data against the model. In this way each result is checked in exactly the cycle it is due. MISO changes on every cycle, so a capture taken one cycle early or late shows up as a wrong receive word.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;

  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 5;
  localparam int NUM_CS   = 8;
  localparam int CS_IDX_W = $clog2(NUM_CS);
  localparam int WORD_MAX = 16;
  localparam int WORD_MIN = 8;
  localparam int EDGE_W   = $clog2(2 * WORD_MAX + 1);
  localparam int BITCNT_W = $clog2(WORD_MAX + 1);
  localparam int SDLY_W   = 2;
  localparam logic [SDLY_W-1:0] SDLY_RESET = SDLY_W'(1);

  // field positions software relies on
  localparam int CTRL_ASSERT_BIT = 0;
  localparam int CTRL_BUSY_BIT   = 1;
  localparam int CTRL_IDX_LSB    = 2;
  localparam int CFG_WIDE_BIT    = 5;
  localparam int CFG_CPOL_BIT    = 11;
  localparam int CFG_CPHA_BIT    = 12;
  localparam int CFG_TXLSB_BIT   = 13;
  localparam int CFG_RXLSB_BIT   = 14;
  localparam int TIM_DLY_LSB     = 6;

  // word index = byte address / 4
  typedef enum logic [2:0] {
    RSEL_CTRL   = 3'd0,
    RSEL_CFG    = 3'd1,
    RSEL_TXD    = 3'd2,
    RSEL_RXD    = 3'd3,
    RSEL_CAUSE  = 3'd4,
    RSEL_TIMING = 3'd6
  } rsel_e;

  typedef struct packed {
    logic rx_lsb;
    logic tx_lsb;
    logic cpha;
    logic cpol;
    logic wide;
  } xfer_cfg_t;

  function automatic logic [WORD_MAX-1:0] mirror_long(input logic [WORD_MAX-1:0] v);
    logic [WORD_MAX-1:0] r;
    for (int i = 0; i < WORD_MAX; i++) r[i] = v[WORD_MAX-1-i];
    return r;
  endfunction

  function automatic logic [WORD_MIN-1:0] mirror_short(input logic [WORD_MIN-1:0] v);
    logic [WORD_MIN-1:0] r;
    for (int i = 0; i < WORD_MIN; i++) r[i] = v[WORD_MIN-1-i];
    return r;
  endfunction

endpackage

// File: rtl/spi_host_regs.sv
`timescale 1ns/1ps
module spi_host_regs
  import spi_host_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                busy_i,
  input  logic                finish_i,
  input  logic [WORD_MAX-1:0] rx_word_i,
  output xfer_cfg_t           cfg_o,
  output logic                cs_on_o,
  output logic [CS_IDX_W-1:0] cs_idx_o,
  output logic [SDLY_W-1:0]   dly_o,
  output logic                start_o,
  output logic [WORD_MAX-1:0] tx_word_o
);

  rsel_e                rsel;
  logic                 wr_en;
  logic [BUS_W-1:0]     rd_word;
  logic                 unused_bus;

  logic                 cs_on_q, cs_on_d;
  logic [CS_IDX_W-1:0]  cs_idx_q, cs_idx_d;
  xfer_cfg_t            cfg_q, cfg_d;
  logic [SDLY_W-1:0]    dly_q, dly_d;
  logic [WORD_MAX-1:0]  txd_q, txd_d;
  logic [WORD_MAX-1:0]  rxd_q, rxd_d;
  logic                 cause_q, cause_d;

  assign unused_bus = ^{bus_addr, bus_wdata};

  always_comb begin
    rsel    = rsel_e'(bus_addr[4:2]);
    wr_en   = bus_sel & bus_wr;
    start_o = wr_en && (rsel == RSEL_TXD) && !busy_i;

    cs_on_d  = cs_on_q;
    cs_idx_d = cs_idx_q;
    cfg_d    = cfg_q;
    dly_d    = dly_q;
    txd_d    = txd_q;
    rxd_d    = finish_i ? rx_word_i : rxd_q;
    cause_d  = cause_q;

    if (wr_en) begin
      case (rsel)
        RSEL_CTRL: begin
          cs_on_d  = bus_wdata[CTRL_ASSERT_BIT];
          cs_idx_d = bus_wdata[CTRL_IDX_LSB +: CS_IDX_W];
        end
        RSEL_CFG: begin
          cfg_d.wide   = bus_wdata[CFG_WIDE_BIT];
          cfg_d.cpol   = bus_wdata[CFG_CPOL_BIT];
          cfg_d.cpha   = bus_wdata[CFG_CPHA_BIT];
          cfg_d.tx_lsb = bus_wdata[CFG_TXLSB_BIT];
          cfg_d.rx_lsb = bus_wdata[CFG_RXLSB_BIT];
        end
        RSEL_TXD:    if (!busy_i) txd_d = bus_wdata[WORD_MAX-1:0];
        RSEL_CAUSE:  cause_d = 1'b0;
        RSEL_TIMING: dly_d = bus_wdata[TIM_DLY_LSB +: SDLY_W];
        default: ;
      endcase
    end
    if (finish_i) cause_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_on_q  <= 1'b0;
      cs_idx_q <= '0;
      cfg_q    <= '0;
      dly_q    <= SDLY_RESET;
      txd_q    <= '0;
      rxd_q    <= '0;
      cause_q  <= 1'b0;
    end else begin
      cs_on_q  <= cs_on_d;
      cs_idx_q <= cs_idx_d;
      cfg_q    <= cfg_d;
      dly_q    <= dly_d;
      txd_q    <= txd_d;
      rxd_q    <= rxd_d;
      cause_q  <= cause_d;
    end
  end

  always_comb begin
    rd_word = '0;
    case (rsel)
      RSEL_CTRL: begin
        rd_word[CTRL_ASSERT_BIT]              = cs_on_q;
        rd_word[CTRL_BUSY_BIT]                = busy_i;
        rd_word[CTRL_IDX_LSB +: CS_IDX_W]     = cs_idx_q;
      end
      RSEL_CFG: begin
        rd_word[CFG_WIDE_BIT]  = cfg_q.wide;
        rd_word[CFG_CPOL_BIT]  = cfg_q.cpol;
        rd_word[CFG_CPHA_BIT]  = cfg_q.cpha;
        rd_word[CFG_TXLSB_BIT] = cfg_q.tx_lsb;
        rd_word[CFG_RXLSB_BIT] = cfg_q.rx_lsb;
      end
      RSEL_TXD:    rd_word[WORD_MAX-1:0] = txd_q;
      RSEL_RXD:    rd_word[WORD_MAX-1:0] = rxd_q;
      RSEL_CAUSE:  rd_word[0] = cause_q;
      RSEL_TIMING: rd_word[TIM_DLY_LSB +: SDLY_W] = dly_q;
      default: ;
    endcase
    bus_rdata = (bus_sel && !bus_wr) ? rd_word : '0;
  end

  assign cfg_o     = cfg_q;
  assign cs_on_o   = cs_on_q;
  assign cs_idx_o  = cs_idx_q;
  assign dly_o     = dly_q;
  assign tx_word_o = txd_q;

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rsel == RSEL_TXD && busy_i) |=> $stable(txd_q)); // R12
  AST_CAUSE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    finish_i |=> cause_q); // R11
  AST_RXD_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    finish_i |=> (rxd_q == $past(rx_word_i))); // R10

endmodule

// File: rtl/spi_host_engine.sv
`timescale 1ns/1ps
module spi_host_engine
  import spi_host_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [WORD_MAX-1:0] tx_word_i,
  input  logic                wide_i,
  input  logic                cpol_i,
  input  logic                cpha_i,
  input  logic                tx_lsb_i,
  input  logic                sck_tick_i,
  input  logic                samples_done_i,
  output logic                busy_o,
  output logic                finish_o,
  output logic                sample_o,
  output logic                sck_o,
  output logic                mosi_o
);

  localparam logic [EDGE_W-1:0] EDGES_LONG  = EDGE_W'(2 * WORD_MAX);
  localparam logic [EDGE_W-1:0] EDGES_SHORT = EDGE_W'(2 * WORD_MIN);
  localparam int                PAD_W       = WORD_MAX - WORD_MIN;

  logic                busy_q, busy_d;
  logic [EDGE_W-1:0]   ecnt_q, ecnt_d;
  logic                phase_q, phase_d;
  logic [WORD_MAX-1:0] tx_q, tx_d;

  logic [EDGE_W-1:0]   edge_total;
  logic                edges_done;
  logic                tick_ok;
  logic                launch;
  logic [WORD_MAX-1:0] load_word;

  always_comb begin
    edge_total = wide_i ? EDGES_LONG : EDGES_SHORT;
    edges_done = (ecnt_q == edge_total);
    tick_ok    = busy_q & sck_tick_i & ~edges_done;
    sample_o   = tick_ok & (ecnt_q[0] == cpha_i);
    launch     = tick_ok & (ecnt_q[0] != cpha_i) & (ecnt_q != '0)
                 & (ecnt_q != (edge_total - EDGE_W'(1)));
    finish_o   = busy_q & edges_done & samples_done_i;

    if (wide_i)
      load_word = tx_lsb_i ? mirror_long(tx_word_i) : tx_word_i;
    else
      load_word = {(tx_lsb_i ? mirror_short(tx_word_i[WORD_MIN-1:0])
                             : tx_word_i[WORD_MIN-1:0]), {PAD_W{1'b0}}};

    busy_d  = busy_q;
    ecnt_d  = ecnt_q;
    phase_d = phase_q;
    tx_d    = tx_q;
    if (start_i) begin
      busy_d  = 1'b1;
      ecnt_d  = '0;
      phase_d = 1'b0;
      tx_d    = load_word;
    end else begin
      if (finish_o) busy_d = 1'b0;
      if (tick_ok) begin
        ecnt_d  = ecnt_q + EDGE_W'(1);
        phase_d = ~phase_q;
      end
      if (launch) tx_d = {tx_q[WORD_MAX-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ecnt_q  <= '0;
      phase_q <= 1'b0;
      tx_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      ecnt_q  <= ecnt_d;
      phase_q <= phase_d;
      tx_q    <= tx_d;
    end
  end

  assign busy_o = busy_q;
  assign sck_o  = cpol_i ^ phase_q;
  assign mosi_o = busy_q & tx_q[WORD_MAX-1];

  AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt_q <= EDGES_LONG); // R4
  AST_IDLE_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (sck_o == cpol_i)); // R4
  AST_IDLE_MOSI: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mosi_o); // R3
  AST_FINISH_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |=> !busy_q); // R10

endmodule

// File: rtl/spi_host_sampler.sv
`timescale 1ns/1ps
module spi_host_sampler
  import spi_host_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                strobe_i,
  input  logic [SDLY_W-1:0]   dly_i,
  input  logic                miso_i,
  input  logic                wide_i,
  input  logic                rx_lsb_i,
  output logic                samples_done_o,
  output logic [WORD_MAX-1:0] rx_word_o
);

  localparam int DEPTH = (1 << SDLY_W) - 1;
  localparam logic [BITCNT_W-1:0] BITS_LONG  = BITCNT_W'(WORD_MAX);
  localparam logic [BITCNT_W-1:0] BITS_SHORT = BITCNT_W'(WORD_MIN);

  logic [DEPTH-1:0]    pipe_q;
  logic [DEPTH:0]      taps;
  logic                take;
  logic [WORD_MAX-1:0] rx_q, rx_d;
  logic [BITCNT_W-1:0] rcnt_q, rcnt_d;

  generate
    if (DEPTH == 1) begin : g_pipe_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= strobe_i;
      end
    end else begin : g_pipe_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[DEPTH-2:0], strobe_i};
      end
    end
  endgenerate

  always_comb begin
    taps = {pipe_q, strobe_i};
    take = taps[dly_i];
    rx_d   = rx_q;
    rcnt_d = rcnt_q;
    if (start_i) begin
      rx_d   = '0;
      rcnt_d = '0;
    end else if (take) begin
      rx_d   = {rx_q[WORD_MAX-2:0], miso_i};
      rcnt_d = rcnt_q + BITCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      rcnt_q <= '0;
    end else begin
      rx_q   <= rx_d;
      rcnt_q <= rcnt_d;
    end
  end

  always_comb begin
    samples_done_o = (rcnt_q == (wide_i ? BITS_LONG : BITS_SHORT));
    if (wide_i)
      rx_word_o = rx_lsb_i ? mirror_long(rx_q) : rx_q;
    else
      rx_word_o = {{(WORD_MAX-WORD_MIN){1'b0}},
                   (rx_lsb_i ? mirror_short(rx_q[WORD_MIN-1:0]) : rx_q[WORD_MIN-1:0])};
  end

  AST_SAMPLE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt_q <= BITS_LONG); // R9
  AST_TAKE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !start_i) |=> (rcnt_q == $past(rcnt_q) + BITCNT_W'(1))); // R9

endmodule

// File: rtl/spi_host_csdec.sv
`timescale 1ns/1ps
module spi_host_csdec
  import spi_host_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_on_i,
  input  logic [CS_IDX_W-1:0] cs_idx_i,
  output logic [NUM_CS-1:0]   cs_n_o
);

  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
      assign cs_n_o[g] = ~(cs_on_i && (cs_idx_i == CS_IDX_W'(g)));
    end
  endgenerate

  AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n_o) <= 1); // R2
  AST_NONE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_on_i |-> (&cs_n_o)); // R2

endmodule

// File: rtl/spi_host_ctrl.sv
`timescale 1ns/1ps
module spi_host_ctrl
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              sck_tick,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);

  xfer_cfg_t           cfg;
  logic                cs_on;
  logic [CS_IDX_W-1:0] cs_idx;
  logic [SDLY_W-1:0]   dly;
  logic                start;
  logic [WORD_MAX-1:0] tx_word;
  logic [WORD_MAX-1:0] rx_word;
  logic                busy;
  logic                finish;
  logic                strobe;
  logic                samples_done;

  spi_host_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy_i    (busy),
    .finish_i  (finish),
    .rx_word_i (rx_word),
    .cfg_o     (cfg),
    .cs_on_o   (cs_on),
    .cs_idx_o  (cs_idx),
    .dly_o     (dly),
    .start_o   (start),
    .tx_word_o (tx_word)
  );

  spi_host_engine u_engine (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .tx_word_i      (bus_wdata[WORD_MAX-1:0]),
    .wide_i         (cfg.wide),
    .cpol_i         (cfg.cpol),
    .cpha_i         (cfg.cpha),
    .tx_lsb_i       (cfg.tx_lsb),
    .sck_tick_i     (sck_tick),
    .samples_done_i (samples_done),
    .busy_o         (busy),
    .finish_o       (finish),
    .sample_o       (strobe),
    .sck_o          (spi_sck),
    .mosi_o         (spi_mosi)
  );

  spi_host_sampler u_sampler (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .strobe_i       (strobe),
    .dly_i          (dly),
    .miso_i         (spi_miso),
    .wide_i         (cfg.wide),
    .rx_lsb_i       (cfg.rx_lsb),
    .samples_done_o (samples_done),
    .rx_word_o      (rx_word)
  );

  spi_host_csdec u_csdec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_on_i  (cs_on),
    .cs_idx_i (cs_idx),
    .cs_n_o   (spi_cs_n)
  );

  logic unused_txq;
  assign unused_txq = ^tx_word;

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R3

endmodule

// File: tb/test_spi_host_ctrl.sv
`timescale 1ns/1ps
module test_spi_host_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck_tick = 1'b0;
  logic        spi_sck;
  logic        spi_mosi;
  logic        spi_miso = 1'b0;
  logic [7:0]  spi_cs_n;

  always #4 clk = ~clk;

  spi_host_ctrl i_spi_host_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_tick(sck_tick), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    ended = 0;
  string cur_req = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  bit        m_busy, m_ph, m_cs_on, m_cause;
  bit [2:0]  m_idx;
  bit        m_wide, m_cpol, m_cpha, m_txl, m_rxl, m_sw, m_stxl;
  bit [1:0]  m_dly = 2'd1;
  bit [15:0] m_din, m_dout;
  int        m_e, m_rc, m_bit;
  bit        rxb [16];
  int        due_q[$];
  bit        rd_pend;
  bit [4:0]  rd_addr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit [31:0] exp_read(input bit [4:0] a);
    bit [31:0] v = '0;
    case (a[4:2])
      3'd0: begin v[0] = m_cs_on; v[1] = m_busy; v[4:2] = m_idx; end
      3'd1: begin v[5] = m_wide; v[11] = m_cpol; v[12] = m_cpha; v[13] = m_txl; v[14] = m_rxl; end
      3'd2: v[15:0] = m_dout;
      3'd3: v[15:0] = m_din;
      3'd4: v[0] = m_cause;
      3'd6: v[7:6] = m_dly;
      default: ;
    endcase
    return v;
  endfunction

  function automatic bit exp_mosi();
    int w = m_sw ? 16 : 8;
    if (!m_busy) return 1'b0;
    return m_stxl ? m_dout[m_bit] : m_dout[w-1-m_bit];
  endfunction

  task automatic compare();
    bit [7:0] cs = 8'hFF;
    if (m_cs_on) cs[m_idx] = 1'b0;
    chk("R2", {24'b0, spi_cs_n}, {24'b0, cs});
    chk("R4", {31'b0, spi_sck}, {31'b0, m_cpol ^ m_ph});
    chk("R5", {31'b0, spi_mosi}, {31'b0, exp_mosi()});
    if (rd_pend) chk(cur_req, bus_rdata, exp_read(rd_addr));
  endtask

  task automatic advance(input bit s, input bit w, input bit [4:0] a, input bit [31:0] d,
                         input bit tick, input bit miso);
    int  wd = m_wide ? 16 : 8;
    bit  was_busy = m_busy;
    bit  fin = m_busy && (m_e == 2 * wd) && (m_rc == wd);
    if (tick && m_busy && m_e < 2 * wd) begin
      bit odd = (m_e % 2) == 1;
      if (odd == m_cpha) due_q.push_back(cyc + int'(m_dly));
      if (odd != m_cpha && m_e != 0 && m_e != 2 * wd - 1) m_bit++;
      m_e++;
      m_ph = !m_ph;
    end
    for (int i = 0; i < due_q.size(); ) begin
      if (due_q[i] == cyc) begin
        if (m_rc < 16) rxb[m_rc] = miso;
        m_rc++;
        due_q.delete(i);
      end else i++;
    end
    if (fin) begin
      bit [15:0] v = '0;
      for (int k = 0; k < wd; k++) begin
        if (m_rxl) v[k] = rxb[k];
        else       v[wd-1-k] = rxb[k];
      end
      m_din = v; m_cause = 1'b1; m_busy = 1'b0;
    end
    if (s && w) begin
      case (a[4:2])
        3'd0: begin m_cs_on = d[0]; m_idx = d[4:2]; end
        3'd1: begin m_wide = d[5]; m_cpol = d[11]; m_cpha = d[12]; m_txl = d[13]; m_rxl = d[14]; end
        3'd2: if (!was_busy) begin
          m_dout = d[15:0]; m_busy = 1'b1; m_e = 0; m_rc = 0; m_bit = 0; m_ph = 1'b0;
          m_sw = m_wide; m_stxl = m_txl;
        end
        3'd4: if (!fin) m_cause = 1'b0;
        3'd6: m_dly = d[7:6];
        default: ;
      endcase
    end
  endtask

  task automatic step(input bit s, input bit w, input bit [4:0] a, input bit [31:0] d);
    bit tk;
    @(negedge clk);
    compare();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tk = (cyc % 4) == 0;
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    sck_tick = tk; spi_miso = lfsr[0];
    rd_pend = s && !w; rd_addr = a;
    advance(s, w, a, d, tk, lfsr[0]);
    cyc++;
  endtask

  task automatic wr(input bit [4:0] a, input bit [31:0] d); step(1, 1, a, d); endtask
  task automatic rd(input bit [4:0] a); step(1, 0, a, 0); endtask

  // mode: 0 poll busy, 1 write cause every cycle, 2 attempt a second launch mid-word
  task automatic xfer(input bit [31:0] cfgw, input bit [1:0] dly, input bit [2:0] cs,
                      input bit [15:0] word, input int mode);
    int n = 0;
    wr(5'h18, {24'b0, dly, 6'b0});
    wr(5'h04, cfgw);
    wr(5'h00, {27'b0, cs, 2'b01});
    wr(5'h08, {16'b0, word});
    while (m_busy && n < 400) begin
      if (mode == 1)                wr(5'h10, 32'h5A);
      else if (mode == 2 && n == 20) wr(5'h08, 32'hFFFF);
      else if (mode == 2 && n == 21) rd(5'h08);
      else                           rd(5'h00);
      n++;
    end
    rd(5'h0C);
    rd(5'h10);
    rd(5'h00);
    wr(5'h10, 32'h0);
    rd(5'h10);
    wr(5'h00, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values of every register
    cur_req = "R1";
    rd(5'h00); rd(5'h04); rd(5'h08); rd(5'h0C); rd(5'h10); rd(5'h18);
    // R2: chip-select index and assert bit
    cur_req = "R2";
    wr(5'h00, {27'b0, 3'd5, 2'b01}); rd(5'h00);
    wr(5'h00, {27'b0, 3'd2, 2'b00}); rd(5'h00);
    wr(5'h00, {27'b0, 3'd7, 2'b01}); rd(5'h00);
    // R3 R5: mode 0, 8-bit, MSB first, default delay
    cur_req = "R3";
    xfer(32'h0, 2'd1, 3'd0, 16'h00A5, 0);
    // R4 R6 R9: mode 3, 16-bit, delay 2
    cur_req = "R6";
    xfer(32'h1820, 2'd2, 3'd4, 16'h1234, 0);
    // R7: transmit LSB first only, mode 1, delay 0
    cur_req = "R7";
    xfer(32'h3000, 2'd0, 3'd6, 16'h00C3, 0);
    // R8 R9: receive LSB first only, mode 2, 16-bit, delay 3
    cur_req = "R8";
    xfer(32'h4820, 2'd3, 3'd1, 16'hBEEF, 0);
    // R9: same word, delay 1 versus 3 captures different bits
    cur_req = "R9";
    xfer(32'h0020, 2'd1, 3'd3, 16'h8001, 0);
    // R12: launch attempt while busy is ignored
    cur_req = "R12";
    xfer(32'h0000, 2'd1, 3'd2, 16'h005A, 2);
    // R10 R11: cause written every cycle, completion wins
    cur_req = "R11";
    xfer(32'h1000, 2'd1, 3'd5, 16'h0081, 1);
    // R13: zero transmit word still captures MISO
    cur_req = "R13";
    xfer(32'h0020, 2'd2, 3'd0, 16'h0000, 0);
    // R10: both orders set, 8-bit, mode 3
    cur_req = "R10";
    xfer(32'h7800, 2'd1, 3'd7, 16'h0F1E, 0);
    repeat (6) step(0, 0, 5'h0, 32'h0);
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule